// File: doc/BRIEF.md
# PTP Time-of-Day Timestamp Counter

This block keeps a free-running time of day for stamping packets. The time is held as three fields: 48-bit seconds, 30-bit nanoseconds and 16-bit fractional nanoseconds. On every clock the time moves forward by a programmable period. When the nanoseconds field reaches one billion, it drops back by one billion and the seconds field steps up by one. A small register write port sets the period and a static latency adjustment. The same port stages a time value and then loads it.

When a frame starts, the datapath raises the capture strobe and supplies a tag of its own. On the next cycle the block returns the time that was current at the strobe, plus the adjustment. The result comes out in two layouts: 96 bits holding seconds, nanoseconds and fraction, and 64 bits holding the total nanoseconds and the fraction. The caller's tag comes back with it.

The result is a one-cycle valid pulse with no ready input, so it has no back-pressure. The consumer must take the stamp on the pulse, or read it later from the held outputs. Those outputs keep their value until the next strobe.

Top module: `ptp_tod_stamp`

## Requirements
- R1: After reset the time is zero, the period and adjustment registers are zero, `stamp_valid` is low and both stamps read zero. With a zero period the time stays at zero.
- R2: The write at address 0 sets the period. `cfg_wdata[19:16]` holds whole nanoseconds and `[15:0]` holds the fraction in units of 2^-16 ns. On each clock where no load occurs, the time advances by exactly this amount, with the fraction carrying into the nanoseconds.
- R3: When an advance takes the nanoseconds to 1,000,000,000 or beyond, the nanoseconds drop by one billion and the seconds rise by one, both in that same cycle.
- R4: Addresses 2, 3, 4 and 5 stage a load value:
  - address 2 is seconds bits 31:0;
  - address 3 is seconds bits 47:32, taken from `cfg_wdata[15:0]`;
  - address 4 is nanoseconds, taken from `[29:0]`;
  - address 5 is the fraction, taken from `[15:0]`.
  A write to address 6 copies the staged value into the time on that clock edge, and this load replaces the advance for that cycle.
- R5: A capture strobe sampled high at a clock edge makes `stamp_valid` high for exactly the following cycle. The stamp reflects the time held just before that edge, so a load or advance at the same edge does not affect it. The stamp outputs keep their value until the next strobe.
- R6: The write at address 1 sets the adjustment. `cfg_wdata[31:16]` holds whole nanoseconds and `[15:0]` holds the fraction. The adjustment is added to every captured time, and a nanosecond overflow from this addition carries into the seconds.
- R7: `stamp96` holds seconds in bits 95:48, nanoseconds in 47:16 and the fraction in 15:0.
- R8: `stamp64` holds (seconds × 10^9 + nanoseconds) modulo 2^48 in bits 63:16 and the fraction in 15:0.
- R9: `stamp_tag` returns the `cap_tag` value that was sampled with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cap_strobe | input | 1 | Start-of-frame capture request |
| cap_tag | input | TAG_W | Caller's tag for this capture |
| stamp_valid | output | 1 | One-cycle pulse marking a new stamp |
| stamp96 | output | 96 | Seconds / nanoseconds / fraction stamp |
| stamp64 | output | 64 | Total nanoseconds / fraction stamp |
| stamp_tag | output | TAG_W | Tag returned with the stamp |

## Verification
Two functions can meet on one clock edge: a time load and a capture. The bench provokes this by writing the load address in the same cycle as a strobe. It expects the stamp to hold the pre-load time, which is the time one period after the previous load. The next capture must then show the loaded value with no period added. The seconds rollover and the adjustment carry are also provoked at the capture edge. In each of these cases the bench judges the result against a time it computes itself from the loaded value, the elapsed cycles and the period.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam int FNS_W = 16;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [FNS_W-1:0] fns;
  } tod_t;

  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_ADJUST = 3'd1,
    REG_SEC_LO = 3'd2,
    REG_SEC_HI = 3'd3,
    REG_NSEC   = 3'd4,
    REG_FNSEC  = 3'd5,
    REG_LOAD   = 3'd6
  } cfg_reg_e;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import ptp_tod_pkg::*;
#(
  parameter int PER_NS_W = 4,
  parameter int ADJ_NS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [PER_NS_W-1:0] per_ns_o,
  output logic [FNS_W-1:0]    per_fns_o,
  output logic [ADJ_NS_W-1:0] adj_ns_o,
  output logic [FNS_W-1:0]    adj_fns_o,
  output tod_t                ld_time_o,
  output logic                load_o
);
  localparam int PER_TOP = FNS_W + PER_NS_W - 1;
  localparam int ADJ_TOP = FNS_W + ADJ_NS_W - 1;

  cfg_reg_e sel;
  assign sel    = cfg_reg_e'(addr_i);
  assign load_o = wr_en_i && (sel == REG_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_ns_o  <= '0;
      per_fns_o <= '0;
      adj_ns_o  <= '0;
      adj_fns_o <= '0;
      ld_time_o <= '0;
    end else if (wr_en_i) begin
      case (sel)
        REG_PERIOD: begin
          per_ns_o  <= wdata_i[PER_TOP:FNS_W];
          per_fns_o <= wdata_i[FNS_W-1:0];
        end
        REG_ADJUST: begin
          adj_ns_o  <= wdata_i[ADJ_TOP:FNS_W];
          adj_fns_o <= wdata_i[FNS_W-1:0];
        end
        REG_SEC_LO: ld_time_o.sec[31:0]       <= wdata_i;
        REG_SEC_HI: ld_time_o.sec[SEC_W-1:32] <= wdata_i[SEC_W-33:0];
        REG_NSEC:   ld_time_o.ns              <= wdata_i[NS_W-1:0];
        REG_FNSEC:  ld_time_o.fns             <= wdata_i[FNS_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int PER_NS_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PER_NS_W-1:0] per_ns_i,
  input  logic [FNS_W-1:0]    per_fns_i,
  input  logic                load_i,
  input  tod_t                ld_time_i,
  output tod_t                now_o
);
  localparam logic [NS_W:0] BILLION = (NS_W+1)'(NS_PER_SEC);

  logic [FNS_W:0] fns_sum;
  logic [NS_W:0]  ns_sum;
  logic           wrap;
  tod_t           nxt;

  always_comb begin
    fns_sum = {1'b0, now_o.fns} + {1'b0, per_fns_i};
    ns_sum  = {1'b0, now_o.ns} + (NS_W+1)'(per_ns_i) + (NS_W+1)'(fns_sum[FNS_W]);
    wrap    = (ns_sum >= BILLION);
    nxt.fns = fns_sum[FNS_W-1:0];
    nxt.ns  = wrap ? NS_W'(ns_sum - BILLION) : ns_sum[NS_W-1:0];
    nxt.sec = now_o.sec + SEC_W'(wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      now_o <= '0;
    else if (load_i) now_o <= ld_time_i;
    else             now_o <= nxt;
  end

  // R3
  ns_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (now_o.ns < NS_W'(NS_PER_SEC))) |=> (now_o.ns < NS_W'(NS_PER_SEC)));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((now_o.sec == $past(now_o.sec)) || (now_o.sec == $past(now_o.sec) + 1'b1)));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (now_o == $past(ld_time_i)));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (now_o.ns < 30'd999_999_000)) |=> $stable(now_o.sec));
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import ptp_tod_pkg::*;
#(
  parameter int ADJ_NS_W = 16,
  parameter int TAG_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tod_t                now_i,
  input  logic [ADJ_NS_W-1:0] adj_ns_i,
  input  logic [FNS_W-1:0]    adj_fns_i,
  input  logic                strobe_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic                valid_o,
  output logic [95:0]         stamp96_o,
  output logic [63:0]         stamp64_o,
  output logic [TAG_W-1:0]    tag_o
);
  localparam int TOT_W = 64 - FNS_W;
  localparam logic [NS_W:0] BILLION = (NS_W+1)'(NS_PER_SEC);

  logic [FNS_W:0]   fns_sum;
  logic [NS_W:0]    ns_sum;
  logic             carry_sec;
  tod_t             adj_t;
  logic [TOT_W-1:0] tot_ns;

  always_comb begin
    fns_sum   = {1'b0, now_i.fns} + {1'b0, adj_fns_i};
    ns_sum    = {1'b0, now_i.ns} + (NS_W+1)'(adj_ns_i) + (NS_W+1)'(fns_sum[FNS_W]);
    carry_sec = (ns_sum >= BILLION);
    adj_t.fns = fns_sum[FNS_W-1:0];
    adj_t.ns  = carry_sec ? NS_W'(ns_sum - BILLION) : ns_sum[NS_W-1:0];
    adj_t.sec = now_i.sec + SEC_W'(carry_sec);
    tot_ns    = TOT_W'(adj_t.sec) * TOT_W'(NS_PER_SEC) + TOT_W'(adj_t.ns);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      stamp96_o <= '0;
      stamp64_o <= '0;
      tag_o     <= '0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        stamp96_o <= {adj_t.sec, {(32-NS_W){1'b0}}, adj_t.ns, adj_t.fns};
        stamp64_o <= {tot_ns, adj_t.fns};
        tag_o     <= tag_i;
      end
    end
  end

  // R5
  pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> valid_o);

  // R5
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> !valid_o);

  // R5
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(stamp96_o) && $stable(stamp64_o) && $stable(tag_o)));

  // R7
  ns_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (stamp96_o[47:16] < NS_PER_SEC));

  // R8
  frac_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (stamp64_o[15:0] == stamp96_o[15:0]));
endmodule

// File: rtl/ptp_tod_stamp.sv
module ptp_tod_stamp
  import ptp_tod_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int PER_NS_W = 4,
  parameter int ADJ_NS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             cap_strobe,
  input  logic [TAG_W-1:0] cap_tag,
  output logic             stamp_valid,
  output logic [95:0]      stamp96,
  output logic [63:0]      stamp64,
  output logic [TAG_W-1:0] stamp_tag
);
  logic [PER_NS_W-1:0] per_ns;
  logic [FNS_W-1:0]    per_fns;
  logic [ADJ_NS_W-1:0] adj_ns;
  logic [FNS_W-1:0]    adj_fns;
  tod_t                ld_time;
  tod_t                now;
  logic                load;

  tod_cfg_regs #(.PER_NS_W(PER_NS_W), .ADJ_NS_W(ADJ_NS_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .per_ns_o(per_ns), .per_fns_o(per_fns),
    .adj_ns_o(adj_ns), .adj_fns_o(adj_fns), .ld_time_o(ld_time), .load_o(load)
  );

  tod_counter #(.PER_NS_W(PER_NS_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .per_ns_i(per_ns), .per_fns_i(per_fns),
    .load_i(load), .ld_time_i(ld_time), .now_o(now)
  );

  tod_capture #(.ADJ_NS_W(ADJ_NS_W), .TAG_W(TAG_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .now_i(now), .adj_ns_i(adj_ns),
    .adj_fns_i(adj_fns), .strobe_i(cap_strobe), .tag_i(cap_tag),
    .valid_o(stamp_valid), .stamp96_o(stamp96), .stamp64_o(stamp64),
    .tag_o(stamp_tag)
  );
endmodule

// File: tb/ptp_tod_stamp_tb.sv
module ptp_tod_stamp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [47:0] sec;
    logic [29:0] ns;
    logic [15:0] fns;
    logic [19:0] per;
    logic [31:0] adj;
    logic [7:0]  k;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{48'd0,            30'd0,           16'h0000, 20'h66666, 32'h0000_0000, 8'd10, 8'h11},
    '{48'd5,            30'd999_999_998, 16'h0000, 20'h66666, 32'h0000_0000, 8'd1,  8'h22},
    '{48'h1234,         30'd999_999_999, 16'hFFFF, 20'h10000, 32'h0001_8000, 8'd0,  8'h33},
    '{48'd100,          30'd500,         16'h8000, 20'hFFFFF, 32'hFFFF_FFFF, 8'd7,  8'h44},
    '{48'd1,            30'd0,           16'h0000, 20'h32000, 32'h0002_0000, 8'd40, 8'hA5},
    '{48'h0000_4000_0000, 30'd123,       16'h0000, 20'h66666, 32'h0000_0000, 8'd3,  8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cap_strobe = 1'b0;
  logic [TAG_W-1:0] cap_tag = '0;
  logic stamp_valid;
  logic [95:0] stamp96;
  logic [63:0] stamp64;
  logic [TAG_W-1:0] stamp_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_tod_stamp #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cap_strobe(cap_strobe), .cap_tag(cap_tag),
    .stamp_valid(stamp_valid), .stamp96(stamp96), .stamp64(stamp64),
    .stamp_tag(stamp_tag)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // expected stamps from a time (in 2^-16 ns units)
  function automatic logic [95:0] exp96(input logic [127:0] t);
    logic [127:0] unit = 128'd1_000_000_000 << 16;
    logic [127:0] s = t / unit;
    logic [127:0] r = t % unit;
    return {s[47:0], 32'(r >> 16), r[15:0]};
  endfunction

  function automatic logic [63:0] exp64(input logic [127:0] t);
    logic [127:0] w = t >> 16;
    return {w[47:0], t[15:0]};
  endfunction

  function automatic logic [127:0] tval(input logic [47:0] s, input logic [29:0] n, input logic [15:0] f);
    return (((128'(s) * 128'd1_000_000_000) + 128'(n)) << 16) + 128'(f);
  endfunction

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    logic [127:0] t;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 96'(stamp_valid), 96'd0);
    chk("R1 stamp96 in reset", stamp96, 96'd0);
    chk("R1 stamp64 in reset", 96'(stamp64), 96'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cap_strobe = 1'b1; cap_tag = 8'h77;
    @(negedge clk);
    cap_strobe = 1'b0;
    chk("R1 zero-period time", stamp96, 96'd0);
    chk("R9 tag after reset", 96'(stamp_tag), 96'h77);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 32'(VECS[i].per));
      wr(3'd1, VECS[i].adj);
      wr(3'd2, VECS[i].sec[31:0]);
      wr(3'd3, 32'(VECS[i].sec[47:32]));
      wr(3'd4, 32'(VECS[i].ns));
      wr(3'd5, 32'(VECS[i].fns));
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = 3'd6;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      repeat (int'(VECS[i].k)) @(negedge clk);
      cap_strobe = 1'b1; cap_tag = VECS[i].tag;
      @(negedge clk);
      cap_strobe = 1'b0;
      t = tval(VECS[i].sec, VECS[i].ns, VECS[i].fns)
          + 128'(VECS[i].k) * 128'(VECS[i].per) + 128'(VECS[i].adj);
      chk("R5 valid pulse", 96'(stamp_valid), 96'd1);
      chk("R2 R3 R6 R7 stamp96", stamp96, exp96(t));
      chk("R8 stamp64", 96'(stamp64), 96'(exp64(t)));
      chk("R9 tag", 96'(stamp_tag), 96'(VECS[i].tag));
      @(negedge clk);
      chk("R5 pulse ends", 96'(stamp_valid), 96'd0);
      chk("R5 stamp held", stamp96, exp96(t));
    end

    // R4 / R5 load and capture at the same edge
    wr(3'd0, 32'h10000);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'd7);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd10);
    wr(3'd5, 32'd0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 3'd6;
    @(negedge clk);
    cfg_addr = 3'd4; cfg_wdata = 32'd500;
    @(negedge clk);
    cfg_addr = 3'd6; cap_strobe = 1'b1; cap_tag = 8'hC3;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R5 capture sees pre-load time", stamp96, exp96(tval(48'd7, 30'd11, 16'd0)));
    @(negedge clk);
    cap_strobe = 1'b0;
    chk("R4 load beats increment", stamp96, exp96(tval(48'd7, 30'd500, 16'd0)));
    chk("R5 back-to-back valid", 96'(stamp_valid), 96'd1);

    done = 1'b1;
    finish_sim();
  end
endmodule